// File: doc/BRIEF.md
# Bus Phase Change Sequencer

This block moves a storage-bus target from one information-transfer phase to another. A controller presents a three-bit phase code, or a release request, together with a one-cycle start strobe. The block first compares the request with the phase already on the bus. If they differ, it waits for the initiator's acknowledge line to drop. It then switches the message, command/data and direction lines together on one clock edge and holds `busy` through a settle interval before it pulses `done`.

The settle interval depends on the mode and on the previous phase. A base time always applies. Extra turnaround time is added when the direction line reverses. A legacy compatibility mode adds a long extra settle time, and in that mode a pre-wait is also inserted before any data phase is entered. A bus reset seen while the block waits for acknowledge abandons the change. If the data-transfer engine is not idle when the lines are about to switch, the block leaves the lines alone and flags a fault.

Delays are given in nanoseconds and turned into clock cycles from the clock period parameter. With the default 20 ns clock they are: base 20 cycles, direction turnaround 20 cycles, legacy settle 5000 cycles, legacy data pre-wait 20000 cycles.

Top module: `bus_phase_seq`

## Requirements
- R1: When a request matches the phase in effect, the block pulses `done` in the cycle after the start edge, never raises `busy` and leaves all lines untouched. A release request while outputs are already released counts as a match.
- R2: While `ack_in` is high the block stays busy and does not change any line. The lines switch on the second clock edge after the first edge that samples `ack_in` low.
- R3: If `bus_reset` is high on an edge where the block waits for acknowledge, the change is abandoned: `done` pulses after that edge and the lines and `ctl_oe` are unchanged. Reset takes priority over a simultaneous acknowledge release.
- R4: Phase code bit 2 drives `msg_o`, bit 1 drives `cd_o` and bit 0 drives `io_o`, each high for a set bit. All three lines and `ctl_oe`=1 are updated on the same edge.
- R5: After the lines change, `done` pulses exactly 20 cycles later (400 ns) when the direction line does not reverse and legacy mode is off.
- R6: 20 more cycles (400 ns) are added when the new `io_o` value differs from the previous driven value. Released outputs count as `io_o`=0.
- R7: With `legacy_mode` high at the start strobe, 5000 more cycles (100 us) are added to the settle time of every phase change.
- R8: With `legacy_mode` high, entering a data phase (codes 000 and 001) inserts 20000 cycles (400 us) between the acknowledge check and the line change.
- R9: A release request that is not a match drops `ctl_oe` and all three lines to 0 on the edge where a phase change would apply them, and `done` pulses in that same cycle with no settle time.
- R10: If `xfer_idle` is low on the edge where the lines would change, `eng_fault` and `done` pulse together and the lines and `ctl_oe` stay as they were.
- R11: After reset `ctl_oe`, `msg_o`, `cd_o`, `io_o`, `busy`, `done` and `eng_fault` are all 0, which represents bus-free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe, taken only while idle |
| phase_code | input | 3 | Requested phase: bit 2 message, bit 1 command/data, bit 0 direction |
| phase_release | input | 1 | Request to release the bus instead of driving a phase |
| legacy_mode | input | 1 | Legacy compatibility timing, sampled at start |
| ack_in | input | 1 | Initiator acknowledge, high when asserted |
| bus_reset | input | 1 | Bus reset seen; aborts the acknowledge wait |
| xfer_idle | input | 1 | Data-transfer engine is idle |
| msg_o | output | 1 | Message line drive |
| cd_o | output | 1 | Command/data line drive |
| io_o | output | 1 | Direction line drive |
| ctl_oe | output | 1 | Control line output enable |
| busy | output | 1 | A phase change is in progress |
| done | output | 1 | One-cycle completion pulse |
| eng_fault | output | 1 | One-cycle pulse: engine busy, phase not changed |

## Verification
Two functions can fall on the same edge: the release of acknowledge, which lets the change proceed, and a bus reset, which aborts the wait. The bench holds `ack_in` high after a start and then drops it in the same cycle as it raises `bus_reset`. It requires `done` on the next edge with no change on any line. A second collision comes from random requests in which the engine is sometimes busy exactly when the lines would switch. There the bench requires the fault pulse and no movement on any line.

// File: rtl/bps_pkg.sv
package bps_pkg;
  typedef enum logic [2:0] {
    S_IDLE   = 3'd0,
    S_WAIT   = 3'd1,
    S_PRE    = 3'd2,
    S_APPLY  = 3'd3,
    S_SETTLE = 3'd4
  } seq_state_e;

  localparam int PH_W = 3;

  // data phases carry no message and no command/data bit
  function automatic logic is_data_phase(input logic [PH_W-1:0] code);
    return code[2:1] == 2'b00;
  endfunction
endpackage

// File: rtl/bps_rst_sync.sv
module bps_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain[STAGES-1];
endmodule

// File: rtl/bps_timer.sv
module bps_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/bps_settle_calc.sv
module bps_settle_calc #(
  parameter int CNT_W  = 16,
  parameter int BASE_C = 20,
  parameter int TURN_C = 20,
  parameter int LEG_C  = 5000
) (
  input  logic             old_io,
  input  logic             new_io,
  input  logic             legacy,
  output logic [CNT_W-1:0] load_val
);
  int total;

  always_comb begin
    total = BASE_C;
    if (old_io != new_io) total = total + TURN_C;
    if (legacy)           total = total + LEG_C;
    load_val = CNT_W'(total - 1);
  end
endmodule

// File: rtl/bps_line_drv.sv
module bps_line_drv #(
  parameter int PH_W = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            apply,
  input  logic            release_all,
  input  logic [PH_W-1:0] code,
  output logic [PH_W-1:0] lines,
  output logic            oe
);
  logic [PH_W-1:0] lines_d;
  logic            oe_d, upd_en;

  always_comb begin
    upd_en  = apply || release_all;
    lines_d = apply ? code : '0;
    oe_d    = apply;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lines <= '0;
      oe    <= 1'b0;
    end else if (upd_en) begin
      lines <= lines_d;
      oe    <= oe_d;
    end
  end
endmodule

// File: rtl/bus_phase_seq.sv
module bus_phase_seq #(
  parameter int CLK_NS        = 20,
  parameter int SETTLE_NS     = 400,
  parameter int TURN_NS       = 400,
  parameter int LEG_SETTLE_NS = 100000,
  parameter int LEG_DATA_NS   = 400000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] phase_code,
  input  logic       phase_release,
  input  logic       legacy_mode,
  input  logic       ack_in,
  input  logic       bus_reset,
  input  logic       xfer_idle,
  output logic       msg_o,
  output logic       cd_o,
  output logic       io_o,
  output logic       ctl_oe,
  output logic       busy,
  output logic       done,
  output logic       eng_fault
);
  import bps_pkg::*;

  localparam int BASE_C  = (SETTLE_NS + CLK_NS - 1) / CLK_NS;
  localparam int TURN_C  = (TURN_NS + CLK_NS - 1) / CLK_NS;
  localparam int LEG_C   = (LEG_SETTLE_NS + CLK_NS - 1) / CLK_NS;
  localparam int PRE_C   = (LEG_DATA_NS + CLK_NS - 1) / CLK_NS;
  localparam int SUM_C   = BASE_C + TURN_C + LEG_C;
  localparam int MAX_C   = (SUM_C > PRE_C) ? SUM_C : PRE_C;
  localparam int CNT_W   = $clog2(MAX_C + 1);
  localparam logic [CNT_W-1:0] PRE_LOAD = CNT_W'(PRE_C - 1);

  logic             rst_sync_n;
  seq_state_e       st_q, st_d;
  logic [PH_W-1:0]  req_code_q, lines;
  logic             req_rel_q, req_leg_q, cap_en;
  logic             done_d, fault_d, same_req;
  logic             tmr_load, tmr_expired, drv_apply, drv_release;
  logic [CNT_W-1:0] tmr_val, settle_val;

  bps_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  bps_settle_calc #(
    .CNT_W(CNT_W), .BASE_C(BASE_C), .TURN_C(TURN_C), .LEG_C(LEG_C)
  ) u_calc (
    .old_io(lines[0] & ctl_oe), .new_io(req_code_q[0]),
    .legacy(req_leg_q), .load_val(settle_val)
  );

  bps_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_sync_n), .load(tmr_load),
    .load_val(tmr_val), .expired(tmr_expired)
  );

  bps_line_drv #(.PH_W(PH_W)) u_drv (
    .clk(clk), .rst_n(rst_sync_n), .apply(drv_apply),
    .release_all(drv_release), .code(req_code_q),
    .lines(lines), .oe(ctl_oe)
  );

  always_comb begin
    same_req = phase_release ? !ctl_oe : (ctl_oe && (phase_code == lines));
  end

  always_comb begin
    st_d        = st_q;
    cap_en      = 1'b0;
    done_d      = 1'b0;
    fault_d     = 1'b0;
    tmr_load    = 1'b0;
    tmr_val     = settle_val;
    drv_apply   = 1'b0;
    drv_release = 1'b0;
    case (st_q)
      S_IDLE: begin
        if (start) begin
          cap_en = 1'b1;
          if (same_req) done_d = 1'b1;
          else          st_d   = S_WAIT;
        end
      end
      S_WAIT: begin
        if (bus_reset) begin
          done_d = 1'b1;
          st_d   = S_IDLE;
        end else if (!ack_in) begin
          if (req_leg_q && !req_rel_q && is_data_phase(req_code_q)) begin
            tmr_load = 1'b1;
            tmr_val  = PRE_LOAD;
            st_d     = S_PRE;
          end else begin
            st_d = S_APPLY;
          end
        end
      end
      S_PRE: begin
        if (tmr_expired) st_d = S_APPLY;
      end
      S_APPLY: begin
        if (!xfer_idle) begin
          fault_d = 1'b1;
          done_d  = 1'b1;
          st_d    = S_IDLE;
        end else if (req_rel_q) begin
          drv_release = 1'b1;
          done_d      = 1'b1;
          st_d        = S_IDLE;
        end else begin
          drv_apply = 1'b1;
          tmr_load  = 1'b1;
          st_d      = S_SETTLE;
        end
      end
      S_SETTLE: begin
        if (tmr_expired) begin
          done_d = 1'b1;
          st_d   = S_IDLE;
        end
      end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      st_q      <= S_IDLE;
      done      <= 1'b0;
      eng_fault <= 1'b0;
    end else begin
      st_q      <= st_d;
      done      <= done_d;
      eng_fault <= fault_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      req_code_q <= '0;
      req_rel_q  <= 1'b0;
      req_leg_q  <= 1'b0;
    end else if (cap_en) begin
      req_code_q <= phase_code;
      req_rel_q  <= phase_release;
      req_leg_q  <= legacy_mode;
    end
  end

  assign msg_o = lines[2];
  assign cd_o  = lines[1];
  assign io_o  = lines[0];
  assign busy  = (st_q != S_IDLE);

  // R2: acknowledge held keeps the sequencer waiting with lines frozen
  p_wait_ack_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q == S_WAIT && ack_in && !bus_reset) |=> (st_q == S_WAIT) && $stable({ctl_oe, lines}));

  // R3: bus reset in the wait aborts without touching the lines
  p_abort_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q == S_WAIT && bus_reset) |=> done && $stable({ctl_oe, lines}));

  // R5: lines stay put through the settle interval
  p_settle_hold_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (st_q == S_SETTLE) |=> $stable({ctl_oe, lines}));

  // R9: a release leaves every line inactive and completes at once
  p_release_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(ctl_oe) |-> (lines == '0) && done);

  // R10: a fault never coincides with a line change
  p_fault_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    eng_fault |-> done && $stable({ctl_oe, lines}));

  // R1: completion is only reported once the sequencer is idle again
  p_done_idle_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    done |-> !busy);
endmodule

// File: tb/sim_bus_phase_seq.sv
module sim_bus_phase_seq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [2:0] phase_code = 3'd0;
  logic       phase_release = 1'b0;
  logic       legacy_mode = 1'b0;
  logic       ack_in = 1'b0;
  logic       bus_reset = 1'b0;
  logic       xfer_idle = 1'b1;
  logic       msg_o, cd_o, io_o, ctl_oe, busy, done, eng_fault;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // bench model of the bus state
  bit       m_oe = 1'b0;
  bit [2:0] m_code = 3'd0;

  always #10 clk = ~clk;

  bus_phase_seq u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .phase_code(phase_code),
    .phase_release(phase_release), .legacy_mode(legacy_mode), .ack_in(ack_in),
    .bus_reset(bus_reset), .xfer_idle(xfer_idle), .msg_o(msg_o), .cd_o(cd_o),
    .io_o(io_o), .ctl_oe(ctl_oe), .busy(busy), .done(done), .eng_fault(eng_fault)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  function automatic int settle_cycles(input bit old_io, input bit new_io, input bit leg);
    int d = 20;
    if (old_io != new_io) d += 20;
    if (leg) d += 5000;
    return d;
  endfunction

  function automatic logic [3:0] bus_vec();
    return {ctl_oe, msg_o, cd_o, io_o};
  endfunction

  // observes from the current negedge; c counts posedges since then
  task automatic watch(input int limit, input logic [3:0] prev,
                       output int tch, output int tdn, output bit flt);
    tch = -1; tdn = -1; flt = 1'b0;
    for (int c = 0; c < limit; c++) begin
      if (c > 0) @(negedge clk);
      if (bus_vec() != prev && tch < 0) tch = c;
      if (eng_fault) flt = 1'b1;
      if (done) begin
        tdn = c;
        break;
      end
    end
  endtask

  task automatic do_phase(input bit rel, input bit [2:0] code, input bit leg, input bit xidle);
    logic [3:0] prev;
    int tch, tdn, exp_ch, exp_dn, pre;
    bit flt, same;
    @(negedge clk);
    prev = bus_vec();
    same = rel ? !m_oe : (m_oe && m_code == code);
    pre  = (leg && !rel && code[2:1] == 2'b00) ? 20000 : 0;
    start = 1'b1; phase_release = rel; phase_code = code;
    legacy_mode = leg; xfer_idle = xidle;
    @(negedge clk);
    start = 1'b0;
    watch(30000, prev, tch, tdn, flt);
    if (same) begin
      chk(tdn == 0, "R1 done on match", tdn, 0);
      chk(tch == -1 && !flt, "R1 lines untouched on match", tch, -1);
    end else if (!xidle) begin
      chk(tdn == 2 + pre && flt, "R10 fault timing", tdn, 2 + pre);
      chk(tch == -1, "R10 lines untouched on fault", tch, -1);
    end else if (rel) begin
      chk(tch == 2 && tdn == 2, "R9 release timing", tdn, 2);
      m_oe = 1'b0; m_code = 3'd0;
    end else begin
      exp_ch = 2 + pre;
      exp_dn = exp_ch + settle_cycles(m_oe & m_code[0], code[0], leg);
      chk(tch == exp_ch, pre > 0 ? "R8 legacy data pre-wait" : "R4 change edge", tch, exp_ch);
      chk(tdn == exp_dn, leg ? "R7 legacy settle" :
          ((m_oe & m_code[0]) != code[0] ? "R6 io turnaround" : "R5 base settle"),
          tdn, exp_dn);
      m_oe = 1'b1; m_code = code;
    end
    chk(bus_vec() == {m_oe, m_code}, "R4 line encoding", int'(bus_vec()), int'({m_oe, m_code}));
    legacy_mode = 1'b0; xfer_idle = 1'b1; phase_release = 1'b0;
  endtask

  initial begin
    #3_000_000;
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=1 expected=0");
      report();
    end
  end

  initial begin
    logic [3:0] prev;
    int tch, tdn;
    bit flt;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R11 reset state
    chk(bus_vec() == 4'd0 && !busy && !done && !eng_fault, "R11 reset state",
        int'({bus_vec(), busy, done, eng_fault}), 0);

    // directed: match from bus-free, then basic moves
    do_phase(1'b1, 3'd0, 1'b0, 1'b1);   // R1 release while released
    do_phase(1'b0, 3'd2, 1'b0, 1'b1);   // R5 command phase, io stays 0
    do_phase(1'b0, 3'd2, 1'b0, 1'b1);   // R1 same phase
    do_phase(1'b0, 3'd3, 1'b0, 1'b1);   // R6 io reverses
    do_phase(1'b0, 3'd7, 1'b0, 1'b0);   // R10 engine busy
    do_phase(1'b1, 3'd0, 1'b0, 1'b1);   // R9 release

    // R2: acknowledge held blocks the change
    @(negedge clk);
    prev = bus_vec();
    ack_in = 1'b1; start = 1'b1; phase_code = 3'd6;
    @(negedge clk);
    start = 1'b0;
    watch(10, prev, tch, tdn, flt);
    chk(tch == -1 && tdn == -1 && busy, "R2 hold while ack high", tch, -1);
    ack_in = 1'b0;
    watch(100, prev, tch, tdn, flt);
    chk(tch == 2, "R2 change after ack drop", tch, 2);
    chk(tdn == 2 + 20, "R5 settle after ack drop", tdn, 22);
    m_oe = 1'b1; m_code = 3'd6;

    // R3: bus reset and ack release in the same cycle
    @(negedge clk);
    prev = bus_vec();
    ack_in = 1'b1; start = 1'b1; phase_code = 3'd1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    ack_in = 1'b0; bus_reset = 1'b1;
    watch(10, prev, tch, tdn, flt);
    bus_reset = 1'b0;
    chk(tdn == 1, "R3 abort done", tdn, 1);
    chk(tch == -1 && bus_vec() == prev, "R3 lines unchanged", int'(bus_vec()), int'(prev));

    // random mix
    for (int i = 0; i < 40; i++) begin
      do_phase(($urandom % 6) == 0, 3'($urandom % 8), 1'b0, ($urandom % 8) != 0);
    end

    // legacy timing
    do_phase(1'b0, 3'd2, 1'b1, 1'b1);   // R7 non-data phase
    do_phase(1'b0, 3'd1, 1'b1, 1'b1);   // R8 data in with pre-wait
    do_phase(1'b0, 3'd0, 1'b1, 1'b0);   // R8 pre-wait then R10 fault

    finished = 1'b1;
    report();
  end
endmodule